// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A memory-mapped watchdog that counts a 16-bit value down to zero and, on expiry, either pulses a system reset request or raises an interrupt. Software keeps it from expiring only by writing two fixed 16-bit key values to a service register, one directly after the other. The enable bit can be set or cleared a single time after power-on reset. A build parameter can instead make the watchdog start running straight out of reset, with no way for software to stop it.

The bus is a plain single-cycle register port. Writes are taken on the rising clock edge when `wr_en` is high, with byte lanes chosen by `byte_en`. Reads are combinational from `addr`. A sticky flag records that the watchdog requested a reset. Software clears it by writing a one. A debug-halt input can hold the countdown while the freeze bit is set.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, with default parameters, the registers read as follows. The status word at byte address 0x00 reads 0 (cause flag in bit 0). The control word at 0x04 reads 0xFFFF0003. Its fields are: time count in bits 31:16, freeze in bit 3, enable in bit 2, reset-select in bit 1 and prescale-enable in bit 0. The count word at 0x08 reads 0x0000FFFF. `irq` and `rst_req` are low. The service word is written at 0x0C, with its key in bits 15:0 and `byte_en[1:0]` both set.
- R2: While the watchdog is disabled, the counter follows the time count and does not decrement. While it is enabled, the counter drops by one on each tick. A tick that arrives with the counter at zero is an expiry, and the counter reloads the time count.
- R3: The first control write that includes byte lane 0 sets the enable bit and locks it. Later writes leave the enable bit unchanged. Time count, freeze, select and prescale stay writable through their byte lanes.
- R4: Writing 0x556C and then, as the very next service write, 0xAA39 reloads the counter from the time count on that second write's edge and clears the prescaler. A completed sequence takes priority over an expiry on the same edge.
- R5: Any other second value breaks the sequence. A lone 0xAA39 does nothing. A repeated 0xAA39 does nothing. A 0x556C following 0x556C leaves the sequence armed.
- R6: With prescale-enable set, a tick comes once every 2^PRESCALE_LOG2 clocks. With it clear, a tick comes on every clock.
- R7: With reset-select at 1, an expiry drives `rst_req` high for one cycle, leaves `irq` alone and sets the cause flag.
- R8: With reset-select at 0, an expiry sets `irq` without touching `rst_req`. `irq` stays high until a service sequence completes, which clears it on that edge.
- R9: Writing 1 to status bit 0 clears the cause flag. Writing 0 leaves it set.
- R10: The count word returns the live counter. Writes to it have no effect.
- R11: With freeze set and `dbg_halt` high, the counter and prescaler hold. When `dbg_halt` drops, counting resumes.
- R12: With POR_ENABLED set, the block leaves reset enabled and locked. Its control word reads back enable as 1, and a write of 0 to enable is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| byte_en | input | 4 | Byte lane enables for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| dbg_halt | input | 1 | Debug halt; freezes counting when the freeze bit is set |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| irq | output | 1 | Expiry interrupt, held until serviced |

## Verification
A table of key-write pairs drives the service tracker through orderings that must and must not reload. These include a stray first key, a doubled arm key, and a fire key that lands while still armed from the previous pair. A tracker that forgot its armed state would reload one cycle late, or not at all, and the count would miss its exact expected value. Directed tests aim a service at the exact edge where the counter would expire. A design that let expiry win there would pulse the reset request or leave the interrupt high. Other directed tests try to turn the enable bit off after it is locked, write the count register, and hold the count under debug halt. Each of these would show a wrong count or enable bit on the read-back. The cause-flag test writes a zero before the clearing one, which catches a flag that clears on any write.

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt #(
  parameter int          PRESCALE_LOG2 = 16,
  parameter bit          POR_ENABLED   = 1'b0,
  parameter int          ADDR_W        = 8,
  parameter logic [15:0] KEY_ARM       = 16'h556C,
  parameter logic [15:0] KEY_FIRE      = 16'hAA39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [3:0]        byte_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              dbg_halt,
  output logic              rst_req,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(8'h0C);

  logic [15:0]              tc_q, cnt_q;
  logic                     frz_q, en_q, lock_q, sel_q, psel_q;
  logic [PRESCALE_LOG2-1:0] pre_q;
  logic                     armed_q, irq_q, rst_q, cause_q;

  logic        ctrl_wr, stat_wr, svc_wr, svc_ok, frozen, run, tick, expire;
  logic [15:0] tc_nx;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign svc_wr  = wr_en && (addr == A_SVC) && (&byte_en[1:0]);
  assign svc_ok  = svc_wr && armed_q && (wdata[15:0] == KEY_FIRE);
  assign frozen  = frz_q && dbg_halt;
  assign run     = en_q && !frozen;
  assign tick    = run && (!psel_q || (&pre_q));
  assign expire  = tick && (cnt_q == 16'd0) && !svc_ok;

  assign tc_nx[15:8] = (ctrl_wr && byte_en[3]) ? wdata[31:24] : tc_q[15:8];
  assign tc_nx[7:0]  = (ctrl_wr && byte_en[2]) ? wdata[23:16] : tc_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q    <= 16'hFFFF;
      cnt_q   <= 16'hFFFF;
      frz_q   <= 1'b0;
      en_q    <= POR_ENABLED;
      lock_q  <= POR_ENABLED;
      sel_q   <= 1'b1;
      psel_q  <= 1'b1;
      pre_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      tc_q <= tc_nx;
      if (ctrl_wr && byte_en[0]) begin
        frz_q  <= wdata[3];
        sel_q  <= wdata[1];
        psel_q <= wdata[0];
        if (!lock_q) begin
          en_q   <= wdata[2];
          lock_q <= 1'b1;
        end
      end
      if (svc_wr) armed_q <= (wdata[15:0] == KEY_ARM);

      if (svc_ok) pre_q <= '0;
      else if (run && psel_q) pre_q <= pre_q + 1'b1;

      if (!en_q) cnt_q <= tc_nx;
      else if (svc_ok || expire) cnt_q <= tc_q;
      else if (tick) cnt_q <= cnt_q - 16'd1;

      rst_q <= expire && sel_q;
      if (svc_ok) irq_q <= 1'b0;
      else if (expire && !sel_q) irq_q <= 1'b1;

      if (stat_wr && byte_en[0] && wdata[0]) cause_q <= 1'b0;
      if (expire && sel_q) cause_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = {31'd0, cause_q};
      A_CTRL:  rdata = {tc_q, 12'd0, frz_q, en_q, sel_q, psel_q};
      A_CNT:   rdata = {16'd0, cnt_q};
      default: rdata = 32'd0;
    endcase
  end

  assign rst_req = rst_q;
  assign irq     = irq_q;

  // R3
  en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(en_q));

  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && frozen && !svc_ok) |=> $stable(cnt_q));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !svc_ok) |=> irq_q);

  // R7
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> cause_q);

  // R4
  reload_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (cnt_q != $past(cnt_q)) && (cnt_q != $past(cnt_q) - 16'd1))
      |-> $past(svc_ok || expire));

endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [7:0]  addr, p_addr;
  logic        wr_en, p_wr;
  logic [3:0]  byte_en, p_be;
  logic [31:0] wdata, p_wdata, rdata, p_rdata;
  logic        dbg_halt, rst_req, irq, p_rst, p_irq;

  int n_chk = 0;
  int n_fail = 0;

  keyed_wdt #(.PRESCALE_LOG2(4)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .byte_en(byte_en),
    .wdata(wdata), .rdata(rdata), .dbg_halt(dbg_halt), .rst_req(rst_req), .irq(irq));

  keyed_wdt #(.PRESCALE_LOG2(4), .POR_ENABLED(1'b1)) i_keyed_wdt_por (
    .clk(clk), .rst_n(rst_n), .addr(p_addr), .wr_en(p_wr), .byte_en(p_be),
    .wdata(p_wdata), .rdata(p_rdata), .dbg_halt(1'b0), .rst_req(p_rst), .irq(p_irq));

  // {first key, second key, outcome}: 0 no reload, 1 reload on second, 2 reload on first
  localparam logic [33:0] SVC_VEC [10] = '{
    {16'h556C, 16'hAA39, 2'd1},
    {16'hAA39, 16'hAA39, 2'd0},
    {16'h556C, 16'h556C, 2'd0},
    {16'hAA39, 16'h0000, 2'd2},
    {16'h556C, 16'h1234, 2'd0},
    {16'hAA39, 16'h556C, 2'd0},
    {16'h0000, 16'hAA39, 2'd0},
    {16'h556C, 16'hAA39, 2'd1},
    {16'h556D, 16'hAA39, 2'd0},
    {16'h556C, 16'hAA38, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    addr = a; wdata = d; byte_en = be; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #0.2; d = rdata;
  endtask

  task automatic service();
    wr(8'h0C, 32'h0000556C, 4'b0011);
    wr(8'h0C, 32'h0000AA39, 4'b0011);
  endtask

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; byte_en = '0; wdata = '0; dbg_halt = 1'b0;
    p_addr = '0; p_wr = 1'b0; p_be = '0; p_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, v); chk("R1 ctrl", v, 32'hFFFF0003);
    rd(8'h08, v); chk("R1 count", v, 32'h0000FFFF);
    rd(8'h00, v); chk("R1 status", v, 32'h0);
    chk("R1 irq/rst", {irq, rst_req}, 2'b00);
    p_addr = 8'h04; #0.2; chk("R12 por ctrl", p_rdata, 32'hFFFF0007);

    // R2 disabled holds
    repeat (20) @(negedge clk);
    rd(8'h08, v); chk("R2 disabled hold", v, 32'h0000FFFF);

    // R2/R8 enable, tc=5, interrupt mode, no prescale
    wr(8'h04, 32'h00050004, 4'b1111);
    rd(8'h08, v); chk("R2 loaded", v, 32'd5);
    repeat (3) @(negedge clk);
    rd(8'h08, v); chk("R2 decrement", v, 32'd2);
    repeat (2) @(negedge clk);
    chk("R8 irq before expiry", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq at expiry", {31'd0, irq}, 32'd1);
    chk("R8 no rst_req", {31'd0, rst_req}, 32'd0);
    rd(8'h08, v); chk("R2 reload on expiry", v, 32'd5);
    repeat (10) @(negedge clk);
    chk("R8 irq held", {31'd0, irq}, 32'd1);
    service();
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    rd(8'h08, v); chk("R4 service beats expiry", v, 32'd5);

    // R3 enable locked
    wr(8'h04, 32'h00050000, 4'b1111);
    rd(8'h04, v); chk("R3 enable kept", v, 32'h00050004);
    rd(8'h08, v); chk("R3 still counting", v, 32'd4);
    wr(8'h04, 32'h03E80000, 4'b1100);
    service();
    rd(8'h04, v); chk("R3 tc writable", v, 32'h03E80004);
    rd(8'h08, v); chk("R4 reload new tc", v, 32'd1000);

    // R4/R5 key sequence table
    for (int i = 0; i < 10; i++) begin
      logic [31:0] e;
      repeat (5) @(negedge clk);
      rd(8'h08, c);
      wr(8'h0C, {16'd0, SVC_VEC[i][33:18]}, 4'b0011);
      wr(8'h0C, {16'd0, SVC_VEC[i][17:2]}, 4'b0011);
      rd(8'h08, v);
      case (SVC_VEC[i][1:0])
        2'd1:    e = 32'd1000;
        2'd2:    e = 32'd999;
        default: e = c - 32'd2;
      endcase
      chk($sformatf("R4/R5 key vector %0d", i), v, e);
    end

    // R10 count write ignored
    rd(8'h08, c);
    wr(8'h08, 32'hFFFFFFFF, 4'b1111);
    rd(8'h08, v); chk("R10 count write ignored", v, c - 32'd1);

    // R11 freeze
    wr(8'h04, 32'h00000008, 4'b0001);
    dbg_halt = 1'b1;
    rd(8'h08, c);
    repeat (5) @(negedge clk);
    rd(8'h08, v); chk("R11 frozen", v, c);
    dbg_halt = 1'b0;
    @(negedge clk);
    rd(8'h08, v); chk("R11 resumes", v, c - 32'd1);

    // R7 reset mode
    wr(8'h04, 32'h00000002, 4'b0001);
    wr(8'h04, 32'h00030000, 4'b1100);
    service();
    repeat (3) @(negedge clk);
    chk("R7 rst_req before expiry", {31'd0, rst_req}, 32'd0);
    @(negedge clk);
    chk("R7 rst_req at expiry", {31'd0, rst_req}, 32'd1);
    chk("R7 irq untouched", {31'd0, irq}, 32'd0);
    rd(8'h00, v); chk("R7 cause set", v, 32'd1);
    @(negedge clk);
    chk("R7 one-cycle pulse", {31'd0, rst_req}, 32'd0);
    wr(8'h04, 32'hFFFF0000, 4'b1100);
    service();

    // R9 cause clear
    wr(8'h00, 32'h0, 4'b0001);
    rd(8'h00, v); chk("R9 write 0 keeps", v, 32'd1);
    wr(8'h00, 32'h1, 4'b0001);
    rd(8'h00, v); chk("R9 write 1 clears", v, 32'd0);

    // R6 prescale (2^4 in this bench)
    wr(8'h04, 32'h00000003, 4'b0001);
    service();
    repeat (15) @(negedge clk);
    rd(8'h08, v); chk("R6 no tick yet", v, 32'h0000FFFF);
    @(negedge clk);
    rd(8'h08, v); chk("R6 tick", v, 32'h0000FFFE);

    // R12 power-on enabled instance
    p_addr = 8'h04; p_wdata = 32'hFFFF0003; p_be = 4'b1111; p_wr = 1'b1;
    @(negedge clk);
    p_wr = 1'b0; #0.2;
    chk("R12 enable stays", p_rdata, 32'hFFFF0007);
    p_addr = 8'h08; #0.2; c = p_rdata;
    repeat (16) @(negedge clk);
    #0.2; chk("R12 counting", p_rdata, c - 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule